// File: doc/BRIEF.md
# Selectable Frame Sync Pattern Detector

This block sits behind a receive demodulator and its clock recovery loop. It watches the recovered serial bit stream for one of four fixed synchronisation words and raises a detect flag once the word has gone by. The flag stays set until the detector is disabled or the receiver is fully powered down. While the detector is armed and has not yet seen the word, the block holds its outgoing data and bit clock high. Downstream logic therefore sees no bit edges and no data until a frame actually starts.

Two select inputs choose the word. The word is either a 16-bit frame word or the same frame word preceded by a 4-bit alternating bit-sync prefix, so one block serves both ends of a link. The recovered data and bit clock are slow signals. They are brought into the fast system clock domain through a synchroniser chain, and their edges are detected there. Bits enter the shift register on a rising bit-clock edge. The flag is updated on a falling bit-clock edge, which is when the data changes. The first bit passed downstream is therefore the one that follows the word.

Top module: `frame_sync_detector`

## Requirements
- R1: While reset is asserted, the detect flag is 0 and both the gated data output and the gated clock output are 1.
- R2: With the prefix select at 0 and the pattern select at 0, the last 16 received bits equal to 0x9336 (oldest bit in bit 15) set the flag.
- R3: With the prefix select at 0 and the pattern select at 1, the last 16 received bits equal to 0xC4D6 set the flag.
- R4: With the prefix select at 1, the last 20 received bits must equal 0xA9336 (pattern select 0) or 0xAC4D6 (pattern select 1) to set the flag. A correct 16-bit tail behind any other 4-bit prefix does not set it.
- R5: While the enable is 0, the flag is 0 and a matching word leaves it at 0. The gated outputs then follow the recovered data and clock.
- R6: While the enable is 1 and the flag is 0, both gated outputs are 1.
- R7: Once set, the flag stays at 1 whatever bits follow, as long as the enable stays 1 and power-down stays 0. From the bit after the word onward, the gated outputs follow the recovered data and clock.
- R8: A power-down indication of 1 clears the flag. While power-down stays at 1, the flag cannot be set.
- R9: The flag changes only at a falling edge of the recovered bit clock, taking the value decided from the bits received up to that edge.
- R10: Bits are taken on rising edges of the recovered bit clock and are compared oldest first. A word sent in reversed bit order does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 1 | Recovered serial data |
| rx_bclk | input | 1 | Recovered bit clock |
| det_en | input | 1 | Detector enable; 0 clears the flag and passes signals through |
| sync_incl | input | 1 | 1 selects the 20-bit word with the bit-sync prefix |
| pat_sel | input | 1 | Chooses between the two frame words |
| pwr_off | input | 1 | Full power-down indication; clears the flag |
| sync_found | output | 1 | Sticky detect flag |
| gated_data | output | 1 | Data output, held at 1 until detection |
| gated_bclk | output | 1 | Bit clock output, held at 1 until detection |

## Verification
The hardest case to reach is a near-miss of the 20-bit word: a correct 16-bit tail behind a wrong prefix. Random data almost never produces it. It is sent on purpose, and so are a bit-reversed word and a word sent while the detector is disabled. A bench model of the shift register then runs against long random streams. In those streams the enable, the selects and the power-down input change at random, and full words are inserted now and then. This tests that the flag sets at the right edge and survives all later traffic.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
  localparam int unsigned FRAME_W  = 16;
  localparam int unsigned PREFIX_W = 4;
  localparam int unsigned FULL_W   = FRAME_W + PREFIX_W;

  localparam logic [FRAME_W-1:0]  FRAME_WORD_0 = 16'h9336;
  localparam logic [FRAME_W-1:0]  FRAME_WORD_1 = 16'hC4D6;
  localparam logic [PREFIX_W-1:0] BITSYNC_PRE  = 4'hA;

  typedef struct packed {
    logic incl;
    logic sel;
  } word_ctl_t;
endpackage

// File: rtl/fsd_edge.sv
module fsd_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic data_in,
  output logic bclk_s,
  output logic data_s,
  output logic rise,
  output logic fall
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clk_pipe;
  logic [SYNC_STAGES-1:0] dat_pipe;
  logic                   clk_prev;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          clk_pipe[i] <= 1'b0;
          dat_pipe[i] <= 1'b1;
        end else begin
          clk_pipe[i] <= bclk_in;
          dat_pipe[i] <= data_in;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          clk_pipe[i] <= 1'b0;
          dat_pipe[i] <= 1'b1;
        end else begin
          clk_pipe[i] <= clk_pipe[i-1];
          dat_pipe[i] <= dat_pipe[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b0;
    else     clk_prev <= clk_pipe[LAST];
  end

  assign bclk_s = clk_pipe[LAST];
  assign data_s = dat_pipe[LAST];
  assign rise   = clk_pipe[LAST] & ~clk_prev;
  assign fall   = ~clk_pipe[LAST] & clk_prev;
endmodule

// File: rtl/fsd_match.sv
module fsd_match
  import fsd_pkg::*;
#(
  parameter int unsigned          SHORT_W = FRAME_W,
  parameter int unsigned          PRE_W   = PREFIX_W,
  parameter logic [SHORT_W-1:0]   WORD_0  = FRAME_WORD_0,
  parameter logic [SHORT_W-1:0]   WORD_1  = FRAME_WORD_1,
  parameter logic [PRE_W-1:0]     PREFIX  = BITSYNC_PRE
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      shift_en,
  input  logic      bit_in,
  input  word_ctl_t ctl,
  output logic      hit
);
  localparam int unsigned LONG_W = SHORT_W + PRE_W;

  logic [LONG_W-1:0]  sr;
  logic [SHORT_W-1:0] frame_sel;
  logic [LONG_W-1:0]  long_sel;

  always_ff @(posedge clk) begin
    if (rst)           sr <= '0;
    else if (shift_en) sr <= {sr[LONG_W-2:0], bit_in};
  end

  always_comb begin
    frame_sel = ctl.sel ? WORD_1 : WORD_0;
    long_sel  = {PREFIX, frame_sel};
    if (ctl.incl) hit = (sr == long_sel);
    else          hit = (sr[SHORT_W-1:0] == frame_sel);
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr)); // R10
  AST_NEWEST_BIT: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sr[0] == $past(bit_in))); // R10
endmodule

// File: rtl/fsd_gate.sv
module fsd_gate (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pwr_off,
  input  logic fall,
  input  logic hit,
  input  logic bclk_s,
  input  logic data_s,
  output logic flag,
  output logic out_data,
  output logic out_bclk
);
  logic hold;

  always_ff @(posedge clk) begin
    if (rst)                 flag <= 1'b0;
    else if (!en || pwr_off) flag <= 1'b0;
    else if (fall && hit)    flag <= 1'b1;
  end

  assign hold = en && !flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data <= 1'b1;
      out_bclk <= 1'b1;
    end else begin
      out_data <= hold ? 1'b1 : data_s;
      out_bclk <= hold ? 1'b1 : bclk_s;
    end
  end

  AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> !flag); // R5
  AST_CLEAR_ON_POWER: assert property (@(posedge clk) disable iff (rst)
    pwr_off |=> !flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && en && !pwr_off) |=> flag); // R7
  AST_SET_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(fall && hit)); // R9
  AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (en && !flag) |=> (out_data && out_bclk)); // R6
endmodule

// File: rtl/frame_sync_detector.sv
module frame_sync_detector
  import fsd_pkg::*;
#(
  parameter int unsigned        SYNC_STAGES = 2,
  parameter int unsigned        SHORT_W     = FRAME_W,
  parameter int unsigned        PRE_W       = PREFIX_W,
  parameter logic [SHORT_W-1:0] WORD_0      = FRAME_WORD_0,
  parameter logic [SHORT_W-1:0] WORD_1      = FRAME_WORD_1,
  parameter logic [PRE_W-1:0]   PREFIX      = BITSYNC_PRE
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_data,
  input  logic rx_bclk,
  input  logic det_en,
  input  logic sync_incl,
  input  logic pat_sel,
  input  logic pwr_off,
  output logic sync_found,
  output logic gated_data,
  output logic gated_bclk
);
  logic      bclk_s, data_s, rise, fall, hit;
  word_ctl_t ctl;

  assign ctl.incl = sync_incl;
  assign ctl.sel  = pat_sel;

  fsd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .bclk_in(rx_bclk), .data_in(rx_data),
    .bclk_s(bclk_s), .data_s(data_s), .rise(rise), .fall(fall)
  );

  fsd_match #(
    .SHORT_W(SHORT_W), .PRE_W(PRE_W),
    .WORD_0(WORD_0), .WORD_1(WORD_1), .PREFIX(PREFIX)
  ) u_match (
    .clk(clk), .rst(rst), .shift_en(rise), .bit_in(data_s),
    .ctl(ctl), .hit(hit)
  );

  fsd_gate u_gate (
    .clk(clk), .rst(rst), .en(det_en), .pwr_off(pwr_off),
    .fall(fall), .hit(hit), .bclk_s(bclk_s), .data_s(data_s),
    .flag(sync_found), .out_data(gated_data), .out_bclk(gated_bclk)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!sync_found && gated_data && gated_bclk)); // R1
endmodule

// File: tb/frame_sync_detector_test.sv
module frame_sync_detector_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, rx_data, rx_bclk, det_en, sync_incl, pat_sel, pwr_off;
  logic sync_found, gated_data, gated_bclk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [19:0] msr;
  logic        mflag;

  frame_sync_detector uut (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_bclk(rx_bclk),
    .det_en(det_en), .sync_incl(sync_incl), .pat_sel(pat_sel),
    .pwr_off(pwr_off), .sync_found(sync_found),
    .gated_data(gated_data), .gated_bclk(gated_bclk)
  );

  function automatic logic [19:0] word_of(logic incl, logic sel);
    logic [15:0] f;
    f = sel ? 16'hC4D6 : 16'h9336;
    return incl ? {4'hA, f} : {4'h0, f};
  endfunction

  function automatic bit model_match(logic [19:0] s, logic incl, logic sel);
    if (incl) return s == word_of(1'b1, sel);
    return s[15:0] == word_of(1'b0, sel)[15:0];
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic phase_check(logic b, logic clk_hi);
    logic hold;
    string tag;
    hold = det_en && !mflag;
    tag = !det_en ? "R5" : (mflag ? "R7" : "R6");
    chk("R9", "flag", sync_found, mflag);
    chk(tag, "data", gated_data, hold ? 1'b1 : b);
    chk(tag, "bclk", gated_bclk, hold ? 1'b1 : clk_hi);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    rx_data = b;
    rx_bclk = 1'b0;
    if (!det_en || pwr_off) mflag = 1'b0;
    else if (model_match(msr, sync_incl, pat_sel)) mflag = 1'b1;
    repeat (7) @(negedge clk);
    phase_check(b, 1'b0);
    repeat (3) @(negedge clk);
    rx_bclk = 1'b1;
    msr = {msr[18:0], b};
    repeat (7) @(negedge clk);
    phase_check(b, 1'b1);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(logic [19:0] w, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_zeros(int n);
    for (int i = 0; i < n; i++) send_bit(1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1; rx_data = 0; rx_bclk = 0; det_en = 0;
    sync_incl = 0; pat_sel = 0; pwr_off = 0;
    msr = '0; mflag = 0;
    repeat (5) @(negedge clk);
    chk("R1", "flag", sync_found, 1'b0);
    chk("R1", "data", gated_data, 1'b1);
    chk("R1", "bclk", gated_bclk, 1'b1);
    rst = 0;

    // R5: word ignored while disabled
    send_word(20'h09336, 16);
    send_bit(1'b0);
    chk("R5", "flag after word while disabled", sync_found, 1'b0);

    // R2: 16-bit word 0
    det_en = 1;
    send_zeros(20);
    send_word(20'h09336, 16);
    send_bit(1'b1);
    chk("R2", "flag after 0x9336", sync_found, 1'b1);

    // R7: sticky under traffic
    for (int i = 0; i < 30; i++) send_bit(1'($urandom));
    chk("R7", "flag after traffic", sync_found, 1'b1);

    // R8: power-down clears
    pwr_off = 1;
    send_bit(1'b0);
    chk("R8", "flag in power-down", sync_found, 1'b0);
    send_word(20'h09336, 16);
    chk("R8", "no set in power-down", sync_found, 1'b0);
    pwr_off = 0;

    // R3: 16-bit word 1
    pat_sel = 1;
    send_zeros(20);
    send_word(20'h0C4D6, 16);
    send_bit(1'b0);
    chk("R3", "flag after 0xC4D6", sync_found, 1'b1);

    // R10: reversed order rejected
    det_en = 0; send_bit(1'b0); det_en = 1;
    pat_sel = 0;
    send_zeros(20);
    send_word(20'h06CC9, 16);
    send_bit(1'b0);
    chk("R10", "reversed word", sync_found, 1'b0);

    // R4: prefixed words
    sync_incl = 1;
    send_zeros(20);
    send_word(20'h59336, 20);
    send_bit(1'b0);
    chk("R4", "wrong prefix", sync_found, 1'b0);
    send_zeros(20);
    send_word(20'hA9336, 20);
    send_bit(1'b0);
    chk("R4", "flag after 0xA9336", sync_found, 1'b1);
    det_en = 0; send_bit(1'b1); det_en = 1;
    pat_sel = 1;
    send_zeros(20);
    send_word(20'hAC4D6, 20);
    send_bit(1'b1);
    chk("R4", "flag after 0xAC4D6", sync_found, 1'b1);

    // random traffic against the model
    for (int i = 0; i < 500; i++) begin
      if ($urandom_range(39) == 0) det_en = ~det_en;
      if ($urandom_range(99) == 0) pwr_off = 1'b1;
      else if (pwr_off && $urandom_range(3) == 0) pwr_off = 1'b0;
      if ($urandom_range(49) == 0) sync_incl = 1'($urandom);
      if ($urandom_range(49) == 0) pat_sel = 1'($urandom);
      if ($urandom_range(29) == 0)
        send_word(word_of(sync_incl, pat_sel), sync_incl ? 20 : 16);
      else
        send_bit(1'($urandom));
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule